// File: doc/BRIEF.md
# Four-Port Shared Byte Memory with Per-Port Write Hold

A single-clock shared memory of 2048 bytes (by default) that four independent ports can reach in the same cycle. Each port has its own address, write data, read data, active-low select, active-low output gate, a read/write select, and an active-low hold input. The hold input lets external logic cancel that port's write without touching its reads. The memory has no internal arbitration. The system is expected to keep two ports from writing the same word together. If that happens anyway, the memory resolves it in a fixed way and raises a sticky flag.

Read data is registered. Each port has an output-valid bit that stands in for driving a bus. The bit is high only after a cycle in which the port was selected, reading, and had its output gate open. During a write the port's output stays quiet, even if its output gate is open. Reset clears only the flag and the valid bits. The stored words survive reset.

Top module: `quad_port_ram`

## Requirements
- R1: The store holds 2**AW words of DW bits (2048 x 8 by default), and every address from 0x000 to 0x7FF can be written and read from any port.
- R2: A port stores its write data into the word at its address at a clock edge where its select is 0, its read/write select is 0 and its hold input is 1.
- R3: While a port's hold input is 0, its write request leaves the memory unchanged, and a read on that port is served as if hold were 1.
- R4: A port whose select is 1 does no access, and its output-valid is 0 after that edge.
- R5: A port with select 0, read/write 1 and output gate 0 shows output-valid 1 and the addressed word on its read data after that edge. With the output gate at 1 it shows output-valid 0.
- R6: After a cycle in which a port requested a write (select 0, read/write 0), its output-valid is 0, whatever its output gate was.
- R7: All four ports may read in the same cycle, at distinct or identical addresses, and each gets its own addressed word.
- R8: A read in the same cycle as a write to that address returns the old word. A read issued on any port in the following cycle returns the new word.
- R9: When two or more ports that are not held write one address in the same cycle, the data of the lowest-numbered of them is stored, and the collision flag is 1 after that edge.
- R10: The collision flag stays 1 until reset. Ports that write one address together while all but one of them is held do not raise it.
- R11: An active-low asynchronous reset clears the collision flag and every output-valid bit. It leaves memory contents unchanged.
- R12: A read has one cycle of latency. A port's read data keeps its last read value through cycles without a read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | NP | Per-port select, active low |
| rw | input | NP | Per-port direction, 1 read, 0 write |
| oe_n | input | NP | Per-port output gate, active low |
| hold_n | input | NP | Per-port write hold, active low |
| addr | input | NP*AW | Per-port word address |
| wdata | input | NP*DW | Per-port write data |
| rdata | output | NP*DW | Per-port registered read data |
| rvalid | output | NP | Per-port output-valid |
| collide | output | 1 | Sticky same-address write collision flag |

## Verification
Four writes to four distinct words are followed by a cross-read pattern, so each port reads a different port's word. This exposes swapped address or data lanes, which a same-port readback would miss. Next come a broadcast read of one address and a read against a write in the same cycle, which separate read-before-write from write-through. Held writes, including one held port that shares an address with a free writer, show that hold gates only the write and never counts toward a collision. A three-writer clash with the lowest writer held shows which port wins, and later idle cycles and a reset show that the flag is sticky and that the memory survives reset.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_HELD  = 2'd3
   } acc_e;

endpackage

// File: rtl/qpr_port_ctl.sv
module qpr_port_ctl
   import qpr_pkg::*;
(
   input  logic sel_n,
   input  logic rw,
   input  logic oe_n,
   input  logic hold_n,
   output logic wr_en,
   output logic rd_en
);

   acc_e acc;

   always_comb begin
      if (sel_n)
         acc = ACC_NONE;
      else if (!rw)
         acc = hold_n ? ACC_WRITE : ACC_HELD;
      else
         acc = oe_n ? ACC_NONE : ACC_READ;
   end

   assign wr_en = (acc == ACC_WRITE);
   assign rd_en = (acc == ACC_READ);

endmodule

// File: rtl/qpr_collide.sv
module qpr_collide #(
   parameter int NP = 4,
   parameter int AW = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NP-1:0]         wr_en,
   input  logic [NP-1:0][AW-1:0] addr,
   output logic                  flag
);

   logic [NP-1:0][NP-1:0] pair;
   logic                  hit;

   for (genvar i = 0; i < NP; i++) begin : g_row
      for (genvar j = 0; j < NP; j++) begin : g_col
         if (j > i) begin : g_cmp
            assign pair[i][j] = wr_en[i] & wr_en[j] & (addr[i] == addr[j]);
         end else begin : g_zero
            assign pair[i][j] = 1'b0;
         end
      end
   end

   assign hit = |pair;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (hit)
         flag <= 1'b1;
   end

endmodule

// File: rtl/qpr_array.sv
module qpr_array #(
   parameter int NP = 4,
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NP-1:0]         wr_en,
   input  logic [NP-1:0]         rd_en,
   input  logic [NP-1:0][AW-1:0] addr,
   input  logic [NP-1:0][DW-1:0] wdata,
   output logic [NP-1:0][DW-1:0] rdata,
   output logic [NP-1:0]         rvalid
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Highest port first, so the lowest-numbered writer lands last and wins.
   always_ff @(posedge clk) begin
      for (int p = NP - 1; p >= 0; p--) begin
         if (wr_en[p])
            mem[addr[p]] <= wdata[p];
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_rd
      always_ff @(posedge clk) begin
         if (rd_en[p])
            rdata[p] <= mem[addr[p]];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rvalid[p] <= 1'b0;
         else
            rvalid[p] <= rd_en[p];
      end
   end

endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram #(
   parameter int NP = 4,
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NP-1:0]         sel_n,
   input  logic [NP-1:0]         rw,
   input  logic [NP-1:0]         oe_n,
   input  logic [NP-1:0]         hold_n,
   input  logic [NP-1:0][AW-1:0] addr,
   input  logic [NP-1:0][DW-1:0] wdata,
   output logic [NP-1:0][DW-1:0] rdata,
   output logic [NP-1:0]         rvalid,
   output logic                  collide
);

   if (NP < 2 || NP > 8) begin : g_bad_np
      $error("quad_port_ram: NP must lie in 2..8");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("quad_port_ram: AW must lie in 1..12");
   end
   if (DW < 1) begin : g_bad_dw
      $error("quad_port_ram: DW must be positive");
   end

   logic [NP-1:0] wr_en;
   logic [NP-1:0] rd_en;

   for (genvar p = 0; p < NP; p++) begin : g_port
      qpr_port_ctl u_ctl (
         .sel_n  (sel_n[p]),
         .rw     (rw[p]),
         .oe_n   (oe_n[p]),
         .hold_n (hold_n[p]),
         .wr_en  (wr_en[p]),
         .rd_en  (rd_en[p])
      );
   end

   qpr_array #(.NP(NP), .AW(AW), .DW(DW)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .rvalid (rvalid)
   );

   qpr_collide #(.NP(NP), .AW(AW)) u_collide (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .flag  (collide)
   );

endmodule

// File: rtl/qpr_checker.sv
module qpr_checker #(
   parameter int NP = 4,
   parameter int DW = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NP-1:0]         sel_n,
   input logic [NP-1:0]         rw,
   input logic [NP-1:0]         oe_n,
   input logic [NP-1:0]         hold_n,
   input logic [NP-1:0][DW-1:0] rdata,
   input logic [NP-1:0]         rvalid,
   input logic                  collide
);

   logic [NP-1:0] free_wr;
   assign free_wr = ~sel_n & ~rw & hold_n;

   for (genvar p = 0; p < NP; p++) begin : g_p
      p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
         sel_n[p] |=> !rvalid[p]);

      p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel_n[p] && rw[p] && !oe_n[p]) |=> rvalid[p]);

      p_gate_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel_n[p] && rw[p] && oe_n[p]) |=> !rvalid[p]);

      p_write_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!sel_n[p] && !rw[p]) |=> !rvalid[p]);

      p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_n[p] || !rw[p] || oe_n[p]) |=> $stable(rdata[p]));
   end

   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> collide);

   p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(collide) |-> ($countones($past(free_wr)) >= 2));

   p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!collide && (rvalid == '0)));

endmodule

bind quad_port_ram qpr_checker #(.NP(NP), .DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n),
   .rw      (rw),
   .oe_n    (oe_n),
   .hold_n  (hold_n),
   .rdata   (rdata),
   .rvalid  (rvalid),
   .collide (collide)
);

// File: tb/quad_port_ram_test.sv
`timescale 1ns/1ps
module quad_port_ram_test;

   localparam int NP = 4;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int NV = 11;

   typedef struct packed {
      logic [3:0]       sel_n;
      logic [3:0]       rw;
      logic [3:0]       oe_n;
      logic [3:0]       hold_n;
      logic [3:0][10:0] a;
      logic [3:0][7:0]  d;
      logic [3:0]       ev;
      logic [3:0][7:0]  ed;
      logic             ec;
   } vec_t;

   // Each concatenation lists port 3 first, port 0 last.
   localparam vec_t VECS [NV] = '{
      '{4'b0000, 4'b0000, 4'b0000, 4'b1111, {11'h123, 11'h400, 11'h7FF, 11'h005},
        {8'hD4, 8'hC3, 8'hB2, 8'hA1}, 4'b0000, 32'h0, 1'b0},
      '{4'b0000, 4'b1111, 4'b0000, 4'b1111, {11'h400, 11'h123, 11'h005, 11'h7FF},
        32'h0, 4'b1111, {8'hC3, 8'hD4, 8'hA1, 8'hB2}, 1'b0},
      '{4'b0000, 4'b1111, 4'b0000, 4'b1111, {11'h005, 11'h005, 11'h005, 11'h005},
        32'h0, 4'b1111, {8'hA1, 8'hA1, 8'hA1, 8'hA1}, 1'b0},
      '{4'b0100, 4'b1110, 4'b1000, 4'b1111, {11'h005, 11'h005, 11'h005, 11'h005},
        {8'h00, 8'h00, 8'h00, 8'h5E}, 4'b0010, {8'h00, 8'h00, 8'hA1, 8'h00}, 1'b0},
      '{4'b0000, 4'b1101, 4'b0000, 4'b1101, {11'h7FF, 11'h005, 11'h7FF, 11'h005},
        {8'h00, 8'h00, 8'hFF, 8'h00}, 4'b1101, {8'hB2, 8'h5E, 8'h00, 8'h5E}, 1'b0},
      '{4'b0101, 4'b1111, 4'b0000, 4'b1101, {11'h7FF, 11'h000, 11'h7FF, 11'h000},
        32'h0, 4'b1010, {8'hB2, 8'h00, 8'hB2, 8'h00}, 1'b0},
      '{4'b1010, 4'b1010, 4'b1111, 4'b1011, {11'h000, 11'h0BB, 11'h000, 11'h0BB},
        {8'h00, 8'h20, 8'h00, 8'h10}, 4'b0000, 32'h0, 1'b0},
      '{4'b0111, 4'b1111, 4'b0111, 4'b1111, {11'h0BB, 11'h000, 11'h000, 11'h000},
        32'h0, 4'b1000, {8'h10, 8'h00, 8'h00, 8'h00}, 1'b0},
      '{4'b0100, 4'b0100, 4'b1111, 4'b1110, {11'h0AA, 11'h000, 11'h0AA, 11'h0AA},
        {8'h33, 8'h00, 8'h11, 8'h99}, 4'b0000, 32'h0, 1'b1},
      '{4'b1011, 4'b1111, 4'b1011, 4'b1111, {11'h000, 11'h0AA, 11'h000, 11'h000},
        32'h0, 4'b0100, {8'h00, 8'h11, 8'h00, 8'h00}, 1'b1},
      '{4'b1111, 4'b1111, 4'b1111, 4'b1111, 44'h0,
        32'h0, 4'b0000, 32'h0, 1'b1}
   };

   function automatic string row_tag(int i);
      case (i)
         0:       return "R2 R6";
         1:       return "R7 R12";
         2:       return "R7";
         3:       return "R8 R4 R5";
         4:       return "R8 R3";
         5:       return "R3";
         6:       return "R10";
         7:       return "R10 R2";
         8:       return "R9";
         9:       return "R9 R10";
         default: return "R10 R4";
      endcase
   endfunction

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NP-1:0]         sel_n = '1;
   logic [NP-1:0]         rw = '1;
   logic [NP-1:0]         oe_n = '1;
   logic [NP-1:0]         hold_n = '1;
   logic [NP-1:0][AW-1:0] addr = '0;
   logic [NP-1:0][DW-1:0] wdata = '0;
   logic [NP-1:0][DW-1:0] rdata;
   logic [NP-1:0]         rvalid;
   logic                  collide;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   quad_port_ram #(.NP(NP), .AW(AW), .DW(DW)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (sel_n),
      .rw      (rw),
      .oe_n    (oe_n),
      .hold_n  (hold_n),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .rvalid  (rvalid),
      .collide (collide)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      sel_n = '1; rw = '1; oe_n = '1; hold_n = '1; addr = '0; wdata = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic one_read(int p, logic [AW-1:0] a);
      idle_all();
      sel_n[p] = 1'b0; oe_n[p] = 1'b0; addr[p] = a;
      tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset rvalid", 32'(rvalid), 32'h0);
      check("R11 reset collide", 32'(collide), 32'h0);
      rst_n = 1'b1;
      tick();

      for (int i = 0; i < NV; i++) begin
         sel_n  = VECS[i].sel_n;
         rw     = VECS[i].rw;
         oe_n   = VECS[i].oe_n;
         hold_n = VECS[i].hold_n;
         addr   = VECS[i].a;
         wdata  = VECS[i].d;
         tick();
         for (int p = 0; p < NP; p++) begin
            check($sformatf("%s row %0d port %0d valid", row_tag(i), i, p),
                  32'(rvalid[p]), 32'(VECS[i].ev[p]));
            if (VECS[i].ev[p])
               check($sformatf("%s row %0d port %0d data", row_tag(i), i, p),
                     32'(rdata[p]), 32'(VECS[i].ed[p]));
         end
         check($sformatf("%s row %0d collide", row_tag(i), i),
               32'(collide), 32'(VECS[i].ec));
      end

      // R1: lowest address written by port 3, read back on port 0
      idle_all();
      sel_n[3] = 1'b0; rw[3] = 1'b0; addr[3] = 11'h000; wdata[3] = 8'h3C;
      tick();
      one_read(0, 11'h000);
      check("R1 addr 0x000 valid", 32'(rvalid[0]), 32'h1);
      check("R1 addr 0x000 data", 32'(rdata[0]), 32'h3C);

      // R12: no read on port 0 keeps its data and drops valid
      idle_all();
      tick();
      check("R12 idle valid", 32'(rvalid[0]), 32'h0);
      check("R12 idle hold data", 32'(rdata[0]), 32'h3C);

      // R11: reset mid-run clears flag, contents stay
      rst_n = 1'b0;
      tick();
      check("R11 mid reset collide", 32'(collide), 32'h0);
      check("R11 mid reset rvalid", 32'(rvalid), 32'h0);
      rst_n = 1'b1;
      tick();
      one_read(1, 11'h0AA);
      check("R11 retained 0x0AA", 32'(rdata[1]), 32'h11);
      one_read(2, 11'h7FF);
      check("R11 retained 0x7FF", 32'(rdata[2]), 32'hB2);
      check("R11 flag stays clear", 32'(collide), 32'h0);

      // R5: read request with the output gate closed
      idle_all();
      sel_n[3] = 1'b0; addr[3] = 11'h0AA;
      tick();
      check("R5 gate closed valid", 32'(rvalid[3]), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule